// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block takes 32-bit avionics words from a host in two 16-bit halves and holds up to eight complete words in a queue. When transmission is enabled it sends the queued words one after another, least significant bit first. The output is bipolar return-to-zero on two logic lines: `line_one` pulses for a one bit and `line_zero` pulses for a zero bit. An external line driver turns these lines into bus levels. Each bit is a data half followed by a null half. Consecutive words are separated by a fixed quiet gap.

Bit 32 can carry either the host's own bit or a generated parity bit, and the parity sense is selectable. A ready flag tells the host when everything it queued has gone out. A loopback port copies the line pair unchanged to one receiver path and swapped, that is complemented, to a second path, so a self test can run while the line outputs stay active. Rate, parity and loopback selections are plain inputs that the host holds steady. A master reset does not change them.

Top module: `a429_serial_tx`

## Requirements
- R1: A word is stored only by a `byte2_stb` pulse that follows a `byte1_stb` pulse with no earlier `byte2_stb` in between. The `byte1_stb` data becomes word bits 16..1 (`host_data[0]` is bit 1). The `byte2_stb` data becomes bits 32..17. A `byte2_stb` pulse with no pending first half is ignored.
- R2: The queue holds eight words. A completed load that arrives while all eight slots are full is dropped, and the eight queued words are sent unchanged.
- R3: `tx_ready` is high after reset. It goes low in the cycle after a word is stored. It goes high in the cycle after the serializer goes idle with the queue empty, which happens at the end of a word gap or when an enable drop abandons a word.
- R4: Let the half-bit length H be 5 clocks when `rate_slow`=0 and 40 clocks when `rate_slow`=1. Each bit has H clocks of data followed by H clocks of null. After the null half of bit 32 there are 8·H null clocks. If enable is still high and another word is queued, its bit 1 starts in the next clock.
- R5: During a data half, a one bit drives `line_one` high and a zero bit drives `line_zero` high. Both lines are low during null halves, gaps and idle, and they are never high together.
- R6: When the transmitter is idle, enable is high and the queue is not empty, the data half of bit 1 of the head word is on the line in the cycle right after the clock edge.
- R7: Generated parity is computed over bits 1..31. With `par_even`=0 it makes the number of ones in all 32 bits odd. With `par_even`=1 it makes that number even.
- R8: Bit 32 is the generated parity when `par_always`=1 or `b32_parity`=1. When both are 0, bit 32 is the stored host bit.
- R9: When `loop_en`=1, `lb1_one`/`lb1_zero` equal `line_one`/`line_zero`, and `lb2_one`/`lb2_zero` equal `line_zero`/`line_one`. When `loop_en`=0 all four are low. The line outputs do not depend on `loop_en`.
- R10: Pulling `rst_n` low at once drives both line outputs low and sets `tx_ready` high. It also empties the queue, so nothing queued before the reset is sent afterwards.
- R11: If `xmit_en` is low while a word or its gap is in progress, the line is idle from the next cycle. That word is discarded, and the next enable starts with the following queued word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| host_data | input | 16 | Host data half |
| byte1_stb | input | 1 | Latch low half (bits 16..1) |
| byte2_stb | input | 1 | Latch high half (bits 32..17) and store word |
| xmit_en | input | 1 | Transmission enable |
| rate_slow | input | 1 | 0: half bit 5 clocks, 1: half bit 40 clocks |
| par_even | input | 1 | Parity sense, 0 odd, 1 even |
| par_always | input | 1 | Forces parity into bit 32 |
| b32_parity | input | 1 | With par_always low: 1 parity, 0 host bit |
| loop_en | input | 1 | Enables the loopback outputs |
| line_one | output | 1 | One-bit pulse line |
| line_zero | output | 1 | Zero-bit pulse line |
| tx_ready | output | 1 | All queued words sent |
| lb1_one | output | 1 | Loopback path 1, ones |
| lb1_zero | output | 1 | Loopback path 1, zeros |
| lb2_one | output | 1 | Loopback path 2 (complemented), ones |
| lb2_zero | output | 1 | Loopback path 2 (complemented), zeros |

## Verification
A word stored at one clock edge can start at the next edge at the earliest, and its first data half is visible right after that edge. `tx_ready` changes one cycle after the store edge or the idle edge. The line and loopback outputs change right after each edge, because they decode registered state. The bench steps a behavioural model at every rising edge from the same sampled inputs. It compares all outputs two time units after that edge, when both model and design have settled. Inputs are driven on the falling edge. A monitor decodes whole words from the pulses so that the exact bit patterns can be checked against hand-computed values.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_BIT  = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_e;
endpackage

// File: rtl/a429_tx_loader.sv
module a429_tx_loader #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte1_stb,
  input  logic              byte2_stb,
  input  logic [WORD_W/2-1:0] host_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic              empty,
  output logic              push
);
  localparam int HALF_W = WORD_W / 2;
  localparam int PTR_W  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic              pend_q, pend_d;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] mem_q [FIFO_DEPTH];
  logic              full, do_pop;

  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign push      = byte2_stb && pend_q && !full;
  assign do_pop    = pop && !empty;
  assign head_word = mem_q[rd_q];

  always_comb begin
    pend_d = pend_q;
    lo_d   = lo_q;
    if (byte1_stb) begin
      pend_d = 1'b1;
      lo_d   = host_data;
    end else if (byte2_stb) begin
      pend_d = 1'b0;
    end
    wr_d = wr_q;
    if (push) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
    rd_d = rd_q;
    if (do_pop) rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q;
    if (push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lo_q   <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      lo_q   <= lo_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= {host_data, lo_q};
  end

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && byte2_stb && !do_pop) |=> (cnt_q == FULL_CNT));

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int HALF_FAST  = 5,
  parameter int HALF_SLOW  = 40,
  parameter int GAP_HALVES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xmit_en,
  input  logic              rate_slow,
  input  logic              par_even,
  input  logic              par_always,
  input  logic              b32_parity,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] head_word,
  output logic              pop,
  output logic              done,
  output logic              line_one,
  output logic              line_zero
);
  localparam int TMR_W = $clog2(HALF_SLOW * GAP_HALVES + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [TMR_W-1:0] HALF_F_C = TMR_W'(HALF_FAST);
  localparam logic [TMR_W-1:0] HALF_S_C = TMR_W'(HALF_SLOW);
  localparam logic [TMR_W-1:0] BIT_F_L  = TMR_W'(2 * HALF_FAST - 1);
  localparam logic [TMR_W-1:0] BIT_S_L  = TMR_W'(2 * HALF_SLOW - 1);
  localparam logic [TMR_W-1:0] GAP_F_L  = TMR_W'(GAP_HALVES * HALF_FAST - 1);
  localparam logic [TMR_W-1:0] GAP_S_L  = TMR_W'(GAP_HALVES * HALF_SLOW - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  ser_state_e        st_q, st_d;
  logic [TMR_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [TMR_W-1:0]  half_len, bit_last, gap_last;
  logic              start, par_gen, last_bit;
  logic [WORD_W-1:0] fill_word;

  assign half_len = rate_slow ? HALF_S_C : HALF_F_C;
  assign bit_last = rate_slow ? BIT_S_L  : BIT_F_L;
  assign gap_last = rate_slow ? GAP_S_L  : GAP_F_L;

  // bit 32 source: generated parity over bits 1..31 or the host bit
  assign par_gen  = par_even ? (^head_word[WORD_W-2:0]) : ~(^head_word[WORD_W-2:0]);
  assign last_bit = (par_always || b32_parity) ? par_gen : head_word[WORD_W-1];
  assign fill_word = {last_bit, head_word[WORD_W-2:0]};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    start  = 1'b0;
    done   = 1'b0;
    unique case (st_q)
      SER_IDLE: begin
        if (xmit_en && !fifo_empty) start = 1'b1;
      end
      SER_BIT: begin
        if (!xmit_en) begin
          st_d = SER_IDLE;
          done = 1'b1;
        end else if (cnt_q == bit_last) begin
          cnt_d = '0;
          if (bidx_q == LAST_IDX) begin
            st_d = SER_GAP;
          end else begin
            bidx_d = bidx_q + 1'b1;
            sh_d   = sh_q >> 1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SER_GAP: begin
        if (!xmit_en) begin
          st_d = SER_IDLE;
          done = 1'b1;
        end else if (cnt_q == gap_last) begin
          if (!fifo_empty) begin
            start = 1'b1;
          end else begin
            st_d = SER_IDLE;
            done = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SER_IDLE;
    endcase
    if (start) begin
      st_d   = SER_BIT;
      cnt_d  = '0;
      bidx_d = '0;
      sh_d   = fill_word;
    end
  end

  assign pop = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SER_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
    end
  end

  assign line_one  = (st_q == SER_BIT) && (cnt_q < half_len) && sh_q[0];
  assign line_zero = (st_q == SER_BIT) && (cnt_q < half_len) && !sh_q[0];

  // R5
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));

  // R11
  en_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SER_IDLE && !xmit_en) |=> (st_q == SER_IDLE));

  // R6
  start_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SER_IDLE && xmit_en && !fifo_empty) |=>
      (st_q == SER_BIT && cnt_q == '0 && bidx_q == '0));

endmodule

// File: rtl/a429_serial_tx.sv
module a429_serial_tx #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int HALF_FAST  = 5,
  parameter int HALF_SLOW  = 40,
  parameter int GAP_HALVES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W/2-1:0] host_data,
  input  logic                byte1_stb,
  input  logic                byte2_stb,
  input  logic                xmit_en,
  input  logic                rate_slow,
  input  logic                par_even,
  input  logic                par_always,
  input  logic                b32_parity,
  input  logic                loop_en,
  output logic                line_one,
  output logic                line_zero,
  output logic                tx_ready,
  output logic                lb1_one,
  output logic                lb1_zero,
  output logic                lb2_one,
  output logic                lb2_zero
);
  logic [1:0]        rs_q;
  logic              rst_s;
  logic              push, pop, done, fifo_empty;
  logic [WORD_W-1:0] head_word;
  logic              rdy_q, rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  a429_tx_loader #(
    .WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_loader (
    .clk(clk), .rst_n(rst_s),
    .byte1_stb(byte1_stb), .byte2_stb(byte2_stb), .host_data(host_data),
    .pop(pop), .head_word(head_word), .empty(fifo_empty), .push(push)
  );

  a429_tx_serializer #(
    .WORD_W(WORD_W), .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW),
    .GAP_HALVES(GAP_HALVES)
  ) u_ser (
    .clk(clk), .rst_n(rst_s),
    .xmit_en(xmit_en), .rate_slow(rate_slow), .par_even(par_even),
    .par_always(par_always), .b32_parity(b32_parity),
    .fifo_empty(fifo_empty), .head_word(head_word),
    .pop(pop), .done(done), .line_one(line_one), .line_zero(line_zero)
  );

  always_comb begin
    rdy_d = rdy_q;
    if (push)                   rdy_d = 1'b0;
    else if (done && fifo_empty) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rdy_q <= 1'b1;
    else        rdy_q <= rdy_d;
  end
  assign tx_ready = rdy_q;

  assign lb1_one  = loop_en & line_one;
  assign lb1_zero = loop_en & line_zero;
  assign lb2_one  = loop_en & line_zero;
  assign lb2_zero = loop_en & line_one;

  // R3
  load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_s)
    push |=> !tx_ready);

  // R3
  idle_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && fifo_empty && !push) |=> tx_ready);

endmodule

// File: tb/sim_a429_serial_tx.sv
module sim_a429_serial_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [15:0] host_data;
  logic        byte1_stb, byte2_stb, xmit_en, rate_slow;
  logic        par_even, par_always, b32_parity, loop_en;
  logic        line_one, line_zero, tx_ready;
  logic        lb1_one, lb1_zero, lb2_one, lb2_zero;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  a429_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .host_data(host_data),
    .byte1_stb(byte1_stb), .byte2_stb(byte2_stb), .xmit_en(xmit_en),
    .rate_slow(rate_slow), .par_even(par_even), .par_always(par_always),
    .b32_parity(b32_parity), .loop_en(loop_en),
    .line_one(line_one), .line_zero(line_zero), .tx_ready(tx_ready),
    .lb1_one(lb1_one), .lb1_zero(lb1_zero), .lb2_one(lb2_one), .lb2_zero(lb2_zero)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_q[$];
  int          m_st;     // 0 idle, 1 sending bits, 2 gap
  int          m_cnt, m_bit;
  logic [31:0] m_word, m_lo;
  logic        m_pend, m_rdy;

  function automatic int half_of(input logic slow);
    return slow ? 40 : 5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_st = 0; m_cnt = 0; m_bit = 0; m_word = '0;
      m_pend = 1'b0; m_lo = '0; m_rdy = 1'b1;
    end else begin
      int  sz, h;
      bit  push, done, start;
      sz = m_q.size();
      h  = half_of(rate_slow);
      push  = byte2_stb && m_pend && (sz < 8);
      done  = 0;
      start = 0;
      if (m_st == 0) begin
        if (xmit_en && sz > 0) start = 1;
      end else if (!xmit_en) begin
        m_st = 0; done = 1;
      end else if (m_st == 1) begin
        if (m_cnt == 2*h - 1) begin
          m_cnt = 0;
          if (m_bit == 31) m_st = 2; else m_bit++;
        end else m_cnt++;
      end else begin
        if (m_cnt == 8*h - 1) begin
          if (sz > 0) start = 1; else begin m_st = 0; done = 1; end
        end else m_cnt++;
      end
      if (start) begin
        logic p;
        m_word = m_q.pop_front();
        p = ^m_word[30:0];
        if (!par_even) p = ~p;
        if (par_always || b32_parity) m_word[31] = p;
        m_st = 1; m_cnt = 0; m_bit = 0;
      end
      if (push) m_q.push_back({host_data, m_lo[15:0]});
      if (byte1_stb) begin m_pend = 1'b1; m_lo = {16'h0, host_data}; end
      else if (byte2_stb) m_pend = 1'b0;
      if (push) m_rdy = 1'b0;
      else if (done && sz == 0) m_rdy = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // word monitor
  logic [31:0] rx_q[$];
  logic [31:0] mon_sh;
  int          mon_nb = 0;
  logic        mon_prev = 1'b0;

  always @(posedge clk) begin
    logic e1, e0, cur;
    #2;
    cyc++;
    e1 = (m_st == 1) && (m_cnt < half_of(rate_slow)) && m_word[m_bit];
    e0 = (m_st == 1) && (m_cnt < half_of(rate_slow)) && !m_word[m_bit];
    chk(line_one === e1 && line_zero === e0, "R4/R5/R6/R11",
        {line_one, line_zero}, {e1, e0});
    chk(tx_ready === m_rdy, "R3", tx_ready, m_rdy);
    chk(lb1_one === (loop_en & e1) && lb1_zero === (loop_en & e0) &&
        lb2_one === (loop_en & e0) && lb2_zero === (loop_en & e1), "R9",
        {lb1_one, lb1_zero, lb2_one, lb2_zero},
        {loop_en & e1, loop_en & e0, loop_en & e0, loop_en & e1});
    cur = line_one | line_zero;
    if (cur && !mon_prev) begin
      mon_sh[mon_nb] = line_one;
      mon_nb++;
      if (mon_nb == 32) begin rx_q.push_back(mon_sh); mon_nb = 0; end
    end
    mon_prev = cur;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic load(input logic [31:0] w);
    @(negedge clk); byte1_stb = 1'b1; host_data = w[15:0];
    @(negedge clk); byte1_stb = 1'b0; byte2_stb = 1'b1; host_data = w[31:16];
    @(negedge clk); byte2_stb = 1'b0; host_data = '0;
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tx_ready) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mon_clear();
    rx_q.delete();
    mon_nb = 0;
  endtask

  initial begin
    rst_n = 1'b0; host_data = '0; byte1_stb = 0; byte2_stb = 0; xmit_en = 0;
    rate_slow = 0; par_even = 0; par_always = 0; b32_parity = 0; loop_en = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R10 reset state
    chk(tx_ready === 1'b1 && line_one === 1'b0 && line_zero === 1'b0, "R10",
        {tx_ready, line_one, line_zero}, 3'b100);

    // R1 R8: host bit 32 kept, halves in order
    mon_clear();
    load(32'hA5C3_1E07);
    xmit_en = 1'b1;
    wait_ready(2000);
    chk(rx_q.size() == 1, "R1", rx_q.size(), 1);
    if (rx_q.size() > 0) chk(rx_q[0] == 32'hA5C3_1E07, "R1 R8", rx_q[0], 32'hA5C3_1E07);
    xmit_en = 1'b0;

    // R1: second-half strobe alone ignored
    @(negedge clk); byte2_stb = 1'b1; host_data = 16'hFFFF;
    @(negedge clk); byte2_stb = 1'b0;
    idle(3);
    chk(tx_ready === 1'b1, "R1", tx_ready, 1);

    // R7: odd then even parity, plus forced parity
    mon_clear();
    b32_parity = 1'b1; loop_en = 1'b1;
    load(32'h0000_0001);
    xmit_en = 1'b1; wait_ready(2000); xmit_en = 1'b0;
    par_even = 1'b1;
    load(32'h0000_0001);
    xmit_en = 1'b1; wait_ready(2000); xmit_en = 1'b0;
    par_even = 1'b0; b32_parity = 1'b0; par_always = 1'b1;
    load(32'h0000_0003);
    xmit_en = 1'b1; wait_ready(2000); xmit_en = 1'b0;
    par_always = 1'b0; loop_en = 1'b0;
    chk(rx_q.size() == 3, "R7", rx_q.size(), 3);
    if (rx_q.size() == 3) begin
      chk(rx_q[0] == 32'h0000_0001, "R7", rx_q[0], 32'h0000_0001);
      chk(rx_q[1] == 32'h8000_0001, "R7", rx_q[1], 32'h8000_0001);
      chk(rx_q[2] == 32'h8000_0003, "R8", rx_q[2], 32'h8000_0003);
    end

    // R2: nine loads into eight slots
    mon_clear();
    for (int i = 0; i < 9; i++) load(32'h100 + i);
    chk(tx_ready === 1'b0, "R3", tx_ready, 0);
    xmit_en = 1'b1;
    wait_ready(5000);
    xmit_en = 1'b0;
    chk(rx_q.size() == 8, "R2", rx_q.size(), 8);
    if (rx_q.size() == 8) begin
      chk(rx_q[0] == 32'h100, "R2", rx_q[0], 32'h100);
      chk(rx_q[7] == 32'h107, "R2", rx_q[7], 32'h107);
    end

    // R4: slow rate, back-to-back words with loopback on
    mon_clear();
    rate_slow = 1'b1; loop_en = 1'b1;
    load(32'h5555_AAAA);
    load(32'h0F0F_F0F0);
    xmit_en = 1'b1;
    wait_ready(8000);
    xmit_en = 1'b0;
    chk(rx_q.size() == 2, "R4", rx_q.size(), 2);
    if (rx_q.size() == 2) chk(rx_q[1] == 32'h0F0F_F0F0, "R4", rx_q[1], 32'h0F0F_F0F0);
    rate_slow = 1'b0; loop_en = 1'b0;

    // R11: drop enable mid-word, next enable sends the following word
    load(32'h0000_0011);
    load(32'h0000_0022);
    xmit_en = 1'b1;
    idle(60);
    xmit_en = 1'b0;
    @(negedge clk);
    chk(line_one === 1'b0 && line_zero === 1'b0, "R11", {line_one, line_zero}, 0);
    idle(5);
    mon_clear();
    xmit_en = 1'b1;
    wait_ready(2000);
    xmit_en = 1'b0;
    chk(rx_q.size() == 1, "R11", rx_q.size(), 1);
    if (rx_q.size() == 1) chk(rx_q[0] == 32'h0000_0022, "R11", rx_q[0], 32'h22);

    // R10: reset mid-transmission empties the queue
    load(32'h0000_0033);
    load(32'h0000_0044);
    load(32'h0000_0055);
    xmit_en = 1'b1;
    idle(50);
    rst_n = 1'b0;
    #1;
    chk(line_one === 1'b0 && line_zero === 1'b0 && tx_ready === 1'b1, "R10",
        {tx_ready, line_one, line_zero}, 3'b100);
    idle(2);
    rst_n = 1'b1;
    mon_clear();
    idle(400);
    chk(rx_q.size() == 0 && mon_nb == 0, "R10", rx_q.size() + mon_nb, 0);
    chk(tx_ready === 1'b1, "R10", tx_ready, 1);
    xmit_en = 1'b0;
    idle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule